// File: doc/BRIEF.md
# Shared Carry-Select Significand Arithmetic Engine

This block does arithmetic on two unsigned significands of `W` bits (53 by default). It uses exactly one adder. That adder is a carry-select structure built from short ripple segments. Each segment prepares its sum and carry for both possible incoming carries, and the real carry from the segment below picks one of the two. Every operation goes through that one adder:

- the operand add,
- the operand subtract,
- each partial-product accumulation of a shift-and-add multiply,
- each trial subtraction of a restoring divide.

A caller presents the operands and a 2-bit operation code, then raises `start` for one cycle while `busy` is low:

- Add and subtract finish at once.
- Multiply and divide take one iteration per significand bit.
- A one-cycle `done` pulse marks the moment `result` and `remainder` hold the new answer.

Exponents, signs and rounding belong to the surrounding unit.

The controller is a small state machine:

| State | Role |
|---|---|
| `ST_IDLE` | Accepts work. Add and subtract complete while in this state. |
| `ST_MUL` | Runs the multiply iterations. |
| `ST_DIV` | Runs the divide iterations. |

Its transitions:

| Transition | Condition |
|---|---|
| `ST_IDLE -> ST_MUL` | `start` with the multiply code |
| `ST_IDLE -> ST_DIV` | `start` with the divide code |
| `ST_MUL -> ST_IDLE` | the last iteration |
| `ST_DIV -> ST_IDLE` | the last iteration |
| `ST_IDLE -> ST_IDLE` | `start` with the add or subtract code, or no `start` |

Top module: `sig_arith_engine`

## Requirements
- R1: The adder is made of SEG_W-bit ripple segments (8 by default; the top segment takes the leftover bits). Each segment above the lowest one selects its sum and carry by the carry arriving from below. The adder's `{carry, sum}` always equals the exact sum of its two operands and its carry-in, including carries that ripple through every segment.
- R2: Code 0 (add) makes `result[W:0]` equal to A+B, with bit W as the carry. All higher result bits are zero and `remainder` is zero.
- R3: Code 1 (subtract) makes `result[W-1:0]` equal to (A-B) mod 2^W, and `result[W]` equal to 1 exactly when A >= B. All higher bits are zero and `remainder` is zero.
- R4: A start with code 0 or 1, accepted while idle, raises `done` in the cycle right after the start edge, and `busy` stays low.
- R5: Code 2 (multiply) makes `result` equal to the full 2W-bit product A*B, with `remainder` zero.
- R6: Code 3 (divide) with B nonzero makes `result[W-1:0]` equal to A/B (truncated) and `remainder` equal to A mod B. All higher result bits are zero.
- R7: Divide with B equal to zero gives a quotient of all ones and a remainder equal to A.
- R8: A multiply or divide start, accepted while idle, raises `busy` from the next cycle for W cycles. `done` then pulses once, W cycles after the start edge, in the same cycle `busy` falls. `done` is never high while `busy` is high.
- R9: A `start` seen while `busy` is high is ignored: the running operation's result, its `done` timing and the operands it uses are unaffected.
- R10: `result` and `remainder` keep their last value until the next completion. After reset, `busy`, `done`, `result` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| opa | input | W | Operand A (addend, minuend, multiplier, dividend) |
| opb | input | W | Operand B (addend, subtrahend, multiplicand, divisor) |
| busy | output | 1 | High while an iterative operation runs |
| done | output | 1 | One-cycle pulse when a new result is available |
| result | output | 2W | Sum, difference with no-borrow flag, product or quotient |
| remainder | output | W | Divide remainder, zero for the other operations |

## Verification
The timing assertions assume `op` holds a legal code whenever `start` is high. They also assume `rst_n` releases away from a clock edge. The bench drives every input at the falling edge and releases reset there. It uses only the four codes and keeps `start` low except in deliberate pulses. Some of those pulses are raised during a running iteration to confirm that start is ignored. A behavioural model in the bench tracks `busy`, `done`, `result` and `remainder` on every clock. The cases it covers are:

- carries that ripple through all segments,
- equal operands and borrowing subtracts,
- all-ones multiplies,
- a dividend smaller than the divisor,
- a zero divisor.

// File: rtl/csa_arith_pkg.sv
package csa_arith_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } state_e;

endpackage

// File: rtl/csel_segment.sv
// One ripple segment. With DIRECT set it ripples from the real carry-in;
// otherwise it prepares results for both carry values and picks one late.
module csel_segment #(
    parameter int SEG_W  = 8,
    parameter bit DIRECT = 1'b0
) (
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             cin,
    output logic [SEG_W-1:0] sum,
    output logic             cout
);

    function automatic logic [SEG_W:0] ripple(input logic [SEG_W-1:0] x,
                                              input logic [SEG_W-1:0] y,
                                              input logic             c);
        logic [SEG_W:0] r;
        logic           k;
        k = c;
        for (int i = 0; i < SEG_W; i++) begin
            r[i] = x[i] ^ y[i] ^ k;
            k    = (x[i] & y[i]) | (k & (x[i] ^ y[i]));
        end
        r[SEG_W] = k;
        return r;
    endfunction

    generate
        if (DIRECT) begin : g_direct
            assign {cout, sum} = ripple(a, b, cin);
        end else begin : g_select
            logic [SEG_W:0] pre0;
            logic [SEG_W:0] pre1;
            assign pre0        = ripple(a, b, 1'b0);
            assign pre1        = ripple(a, b, 1'b1);
            assign {cout, sum} = cin ? pre1 : pre0;
        end
    endgenerate

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int W     = 54,
    parameter int SEG_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int NSEG = (W + SEG_W - 1) / SEG_W;

    logic [NSEG:0] cy;
    assign cy[0] = cin;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam int LO = i * SEG_W;
        localparam int HI = ((LO + SEG_W) > W) ? (W - 1) : (LO + SEG_W - 1);
        localparam int SW = HI - LO + 1;
        csel_segment #(
            .SEG_W  (SW),
            .DIRECT (i == 0)
        ) u_seg (
            .a    (a[HI:LO]),
            .b    (b[HI:LO]),
            .cin  (cy[i]),
            .sum  (sum[HI:LO]),
            .cout (cy[i+1])
        );
    end

    assign cout = cy[NSEG];

endmodule

// File: rtl/sig_arith_engine.sv
module sig_arith_engine
    import csa_arith_pkg::*;
#(
    parameter int W     = 53,
    parameter int SEG_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] result,
    output logic [W-1:0]   remainder
);

    localparam int AW = W + 1;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    state_e         state, state_nxt;
    logic [CW-1:0]  cnt;
    logic [W-1:0]   hi, lo, dvs;
    logic [2*W-1:0] result_q;
    logic [W-1:0]   rem_q;
    logic           done_q;

    logic [AW-1:0]  add_a, add_b, add_sum;
    logic           add_ci, add_co;
    logic           last;

    logic [AW-1:0]  mul_acc;
    logic [W-1:0]   mul_hi_n, mul_lo_n;
    logic [W-1:0]   div_rem_n, div_q_n;

    assign last = (cnt == LAST);

    // operand steering into the single adder
    always_comb begin
        add_a  = {1'b0, opa};
        add_b  = {1'b0, opb};
        add_ci = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (op_e'(op) == OP_SUB) begin
                    add_b  = ~{1'b0, opb};
                    add_ci = 1'b1;
                end
            end
            ST_MUL: begin
                add_a = {1'b0, hi};
                add_b = {1'b0, dvs};
            end
            ST_DIV: begin
                add_a  = {hi, lo[W-1]};
                add_b  = ~{1'b0, dvs};
                add_ci = 1'b1;
            end
            default: ;
        endcase
    end

    csel_adder #(
        .W     (AW),
        .SEG_W (SEG_W)
    ) u_adder (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_ci),
        .sum  (add_sum),
        .cout (add_co)
    );

    // per-iteration next values
    always_comb begin
        mul_acc   = lo[0] ? add_sum : {1'b0, hi};
        mul_hi_n  = mul_acc[AW-1:1];
        mul_lo_n  = {mul_acc[0], lo[W-1:1]};
        div_rem_n = add_co ? add_sum[W-1:0] : {hi[W-2:0], lo[W-1]};
        div_q_n   = {lo[W-2:0], add_co};
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start && op_e'(op) == OP_MUL) state_nxt = ST_MUL;
                if (start && op_e'(op) == OP_DIV) state_nxt = ST_DIV;
            end
            ST_MUL:  if (last) state_nxt = ST_IDLE;
            ST_DIV:  if (last) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            hi       <= '0;
            lo       <= '0;
            dvs      <= '0;
            result_q <= '0;
            rem_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        unique case (op_e'(op))
                            OP_ADD: begin
                                result_q <= {{(2*W-AW){1'b0}}, add_sum};
                                rem_q    <= '0;
                                done_q   <= 1'b1;
                            end
                            OP_SUB: begin
                                result_q <= {{(2*W-AW){1'b0}}, add_co, add_sum[W-1:0]};
                                rem_q    <= '0;
                                done_q   <= 1'b1;
                            end
                            OP_MUL, OP_DIV: begin
                                hi  <= '0;
                                lo  <= opa;
                                dvs <= opb;
                                cnt <= '0;
                            end
                        endcase
                    end
                end
                ST_MUL: begin
                    hi  <= mul_hi_n;
                    lo  <= mul_lo_n;
                    cnt <= cnt + 1'b1;
                    if (last) begin
                        result_q <= {mul_hi_n, mul_lo_n};
                        rem_q    <= '0;
                        done_q   <= 1'b1;
                    end
                end
                ST_DIV: begin
                    hi  <= div_rem_n;
                    lo  <= div_q_n;
                    cnt <= cnt + 1'b1;
                    if (last) begin
                        result_q <= {{W{1'b0}}, div_q_n};
                        rem_q    <= div_rem_n;
                        done_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign result    = result_q;
    assign remainder = rem_q;

    AST_ADDER_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        {add_co, add_sum} == ({1'b0, add_a} + {1'b0, add_b} + {{AW{1'b0}}, add_ci})); // R1
    AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op[1]) |=> (done && !busy)); // R4
    AST_ITER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op[1]) |=> (busy && !done)); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST)); // R8
    AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dvs)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> $stable(result)); // R10

endmodule

// File: tb/tb_sig_arith_engine.sv
`timescale 1ns/1ps
module tb_sig_arith_engine;

    localparam int W = 53;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [1:0]     op = 2'd0;
    logic [W-1:0]   a = '0, b = '0;
    logic           busy, done;
    logic [2*W-1:0] result;
    logic [W-1:0]   remainder;

    always #4 clk = ~clk;

    sig_arith_engine #(.W(W), .SEG_W(8)) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .op (op),
        .opa (a), .opb (b), .busy (busy), .done (done),
        .result (result), .remainder (remainder)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int             m_cnt = 0;
    bit             m_busy = 0, m_done = 0, m_iter = 0;
    logic [2*W-1:0] m_res = '0, p_res = '0;
    logic [W-1:0]   m_rem = '0, p_rem = '0;
    string          m_tag = "R10", p_tag = "R10", cur_tag = "R2";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic expect_of(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                             output logic [2*W-1:0] r, output logic [W-1:0] m);
        r = '0;
        m = '0;
        case (o)
            2'd0: r = (2*W)'(x) + (2*W)'(y);
            2'd1: begin r[W-1:0] = x - y; r[W] = (x >= y); end
            2'd2: r = (2*W)'(x) * (2*W)'(y);
            default: begin
                if (y == 0) begin r[W-1:0] = '1; m = x; end
                else begin r[W-1:0] = x / y; m = x % y; end
            end
        endcase
    endtask

    task automatic tick();
        logic [2*W-1:0] r;
        logic [W-1:0]   m;
        if (m_cnt > 0) begin
            m_cnt--;
            m_busy = (m_cnt > 0);
            m_done = (m_cnt == 0);
            if (m_done) begin m_res = p_res; m_rem = p_rem; m_tag = p_tag; end
        end else if (start) begin
            expect_of(op, a, b, r, m);
            if (!op[1]) begin
                m_done = 1; m_iter = 0; m_res = r; m_rem = m; m_tag = cur_tag;
            end else begin
                m_done = 0; m_iter = 1; m_busy = 1; m_cnt = W;
                p_res = r; p_rem = m; p_tag = cur_tag;
            end
        end else begin
            m_done = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(busy === m_busy, m_iter ? "R8" : "R4", "busy", 106'(busy), 106'(m_busy));
        chk(done === m_done, m_iter ? "R8" : "R4", "done", 106'(done), 106'(m_done));
        chk(result === m_res, m_tag, "result", result, m_res);
        chk(remainder === m_rem, m_tag, "remainder", 106'(remainder), 106'(m_rem));
    endtask

    task automatic run(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input string tag);
        op = o; a = x; b = y; start = 1'b1; cur_tag = tag;
        tick();
        start = 1'b0;
        while (m_busy) tick();
        tick();
    endtask

    function automatic logic [W-1:0] rnd();
        return W'({$urandom(), $urandom()});
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R10", "busy in reset", 106'(busy), '0);
        chk(done === 1'b0, "R10", "done in reset", 106'(done), '0);
        chk(result === '0, "R10", "result in reset", result, '0);
        chk(remainder === '0, "R10", "remainder in reset", 106'(remainder), '0);
        rst_n = 1'b1;
        tick();

        // R1 full carry ripple across every segment
        run(2'd0, '1, W'(1), "R1");
        run(2'd0, '1, '1, "R1");
        run(2'd1, '0, W'(1), "R1");
        // R2 add
        run(2'd0, W'(12345), W'(67890), "R2");
        run(2'd0, '0, '0, "R2");
        // R3 subtract
        run(2'd1, W'(1000), W'(999), "R3");
        run(2'd1, W'(5), W'(9), "R3");
        run(2'd1, W'(77), W'(77), "R3");
        // R4 back-to-back fast operations
        op = 2'd0; a = W'(3); b = W'(4); start = 1'b1; cur_tag = "R4";
        tick();
        op = 2'd1; a = W'(10); b = W'(20);
        tick();
        start = 1'b0;
        tick();
        // R5 multiply
        run(2'd2, '1, '1, "R5");
        run(2'd2, '0, rnd(), "R5");
        run(2'd2, W'(1), rnd(), "R5");
        run(2'd2, W'(1) << (W-1), W'(3), "R5");
        // R6 divide
        run(2'd3, W'(100), W'(7), "R6");
        run(2'd3, W'(3), W'(11), "R6");
        run(2'd3, '1, W'(1), "R6");
        run(2'd3, '1, '1, "R6");
        // R7 zero divisor
        run(2'd3, rnd(), '0, "R7");
        run(2'd3, '1, '0, "R7");
        // R9 start held while busy is ignored
        op = 2'd2; a = rnd(); b = rnd(); start = 1'b1; cur_tag = "R9";
        tick();
        op = 2'd3; a = rnd(); b = W'(5);
        repeat (6) tick();
        start = 1'b0;
        while (m_busy) tick();
        tick();
        // mixed random patterns
        for (int i = 0; i < 8; i++) begin
            run(2'd0, rnd(), rnd(), "R2");
            run(2'd1, rnd(), rnd(), "R3");
            run(2'd2, rnd(), rnd(), "R5");
            run(2'd3, rnd(), rnd() >> (i * 6), "R6");
        end
        summary();
        $finish;
    end

endmodule